// File: doc/BRIEF.md
# Bus Traffic Performance Monitor

This block watches one bus port and counts data beats. It has one free-running cycle counter and four event counters. Each event counter has its own type select, so it can count read beats, write beats, or both. Beat activity arrives as two single-cycle strobes, one for read data and one for write data. When both strobes are active in the same cycle, a counter that selects both kinds adds two.

Software reaches the block through a word-addressed port with separate read and write strobes. One control word starts and stops all counting and clears the counters. A pair of registers turns individual counters on and off: one register sets enable bits where ones are written, and the other clears them. To take a measurement, software clears the counters and starts them in one write, lets traffic run, and then drops the run bit. This freezes every counter, so the cycle count and the beat counts can be read as one consistent snapshot.

Event counter 3 is wider than the others. Its upper bits are read from a separate high word. Software forms the full value as high shifted left by the standard counter width, plus low.

Top module: `bustraf_mon`

## Requirements
- R1: After reset, every counter, enable, type select and the run bit are zero, and every register reads as zero.
- R2: Writing to the enable-set register (address 1) turns on each counter whose mask bit is one and leaves the others unchanged. In the mask, event counter i is bit i and the cycle counter is bit 31. The current enable mask reads back at both address 1 and address 2.
- R3: Writing to the enable-clear register (address 2) turns off each counter whose mask bit is one and leaves the others unchanged.
- R4: In the control register (address 0), bit 0 is the run bit and reads back. Bit 1 clears all event counters and bit 2 clears the cycle counter. The clear takes effect at the edge of the write, and both clear bits always read back as 0. Each clear bit acts only on its own counters.
- R5: The cycle counter (address 3) adds one at every clock edge where run and its enable are both set.
- R6: The type select of event counter i is at address 4+i. Bit 0 selects read beats and bit 1 selects write beats. A counter adds the number of selected strobes that are active at an edge where run and its enable are both set. That is 2 when both strobes are active and both are selected, and 0 when the select is zero.
- R7: While run is 0, no counter changes, whatever the strobes do.
- R8: Event counters 0 to 2 read at addresses 8 to 10. Event counter 3 is CNT_W+EXT_W bits wide: its low CNT_W bits read at address 11 and its upper EXT_W bits, zero-extended, read at address 12.
- R9: Every counter wraps to zero past its maximum value and does not saturate.
- R10: Read data is registered: it is valid on the clock edge after rd_en. Unmapped addresses (13 to 15) read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_beat | input | 1 | One read data beat observed this cycle |
| wr_beat | input | 1 | One write data beat observed this cycle |

## Verification
The hardest behaviour to reach from the ports is counter wrap, and the carry from the low word of counter 3 into its high word. With the default widths, either would take billions of cycles. The bench therefore drives a second instance, built with 8-bit counters, from the same inputs. On that instance, one long burst with both strobes active carries into the high word of counter 3 and wraps the cycle counter, and a burst of about 33,000 cycles wraps the whole 16-bit counter 3. The timing of the clear bits is also hard to observe. The bench checks it by clearing only the cycle counter while an event count is kept, and then the reverse.

// File: rtl/bustraf_pkg.sv
package bustraf_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int NUM_EV = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_EN_SET  = 4'd1,
    A_EN_CLR  = 4'd2,
    A_CYCLE   = 4'd3,
    A_SEL0    = 4'd4,
    A_SEL1    = 4'd5,
    A_SEL2    = 4'd6,
    A_SEL3    = 4'd7,
    A_CNT0    = 4'd8,
    A_CNT1    = 4'd9,
    A_CNT2    = 4'd10,
    A_CNT3_LO = 4'd11,
    A_CNT3_HI = 4'd12
  } reg_addr_e;

  localparam int CTRL_RUN    = 0;
  localparam int CTRL_EV_CLR = 1;
  localparam int CTRL_CY_CLR = 2;
  localparam int CYC_EN_BIT  = 31;
  localparam int SEL_RD      = 0;
  localparam int SEL_WR      = 1;
endpackage

// File: rtl/bustraf_regs.sv
module bustraf_regs import bustraf_pkg::*; (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BUS_W-1:0]             wdata,
  output logic                         run,
  output logic                         ev_clr,
  output logic                         cy_clr,
  output logic [NUM_EV-1:0]            en_ev,
  output logic                         en_cyc,
  output logic [NUM_EV-1:0][1:0]       sel
);
  logic [NUM_EV:0] mask_vec;
  logic [NUM_EV:0] en_vec;
  logic            wr_ctrl, wr_set, wr_clr;
  logic            unused_bits;

  assign mask_vec    = {wdata[CYC_EN_BIT], wdata[NUM_EV-1:0]};
  assign en_vec      = {en_cyc, en_ev};
  assign unused_bits = ^wdata[BUS_W-2:NUM_EV];

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_set  = wr_en && (addr == A_EN_SET);
  assign wr_clr  = wr_en && (addr == A_EN_CLR);

  // Clear requests act in the write cycle only, so they always read back as 0.
  assign ev_clr = wr_ctrl && wdata[CTRL_EV_CLR];
  assign cy_clr = wr_ctrl && wdata[CTRL_CY_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
    end else if (wr_ctrl) begin
      run <= wdata[CTRL_RUN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_ev  <= '0;
      en_cyc <= 1'b0;
    end else if (wr_set) begin
      en_ev  <= en_ev | mask_vec[NUM_EV-1:0];
      en_cyc <= en_cyc | mask_vec[NUM_EV];
    end else if (wr_clr) begin
      en_ev  <= en_ev & ~mask_vec[NUM_EV-1:0];
      en_cyc <= en_cyc & ~mask_vec[NUM_EV];
    end
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) begin
        sel[i] <= 2'b00;
      end else if (wr_en && (addr == ADDR_W'(A_SEL0 + i))) begin
        sel[i] <= wdata[1:0];
      end
    end
  end

  AST_SET_ONES: assert property (@(posedge clk) disable iff (rst) wr_set |=> ((en_vec & $past(mask_vec)) == $past(mask_vec))); // R2
  AST_CLR_ONES: assert property (@(posedge clk) disable iff (rst) wr_clr |=> ((en_vec & $past(mask_vec)) == '0)); // R3
  AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst) (wr_set || wr_clr) |=> ((en_vec & ~$past(mask_vec)) == ($past(en_vec) & ~$past(mask_vec)))); // R2
  AST_RUN_WRITE: assert property (@(posedge clk) disable iff (rst) wr_ctrl |=> (run == $past(wdata[CTRL_RUN]))); // R4
endmodule

// File: rtl/bustraf_cnt.sv
module bustraf_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cnt_en,
  input  logic [1:0]   inc,
  output logic [W-1:0] count
);
  // Wraps modulo 2**W by plain binary addition.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (cnt_en) begin
      count <= count + W'(inc);
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst) clr |=> (count == '0)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst) (!cnt_en && !clr) |=> $stable(count)); // R7
endmodule

// File: rtl/bustraf_mon.sv
module bustraf_mon import bustraf_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int EXT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              rd_beat,
  input  logic              wr_beat
);
  localparam int WIDE_W = CNT_W + EXT_W;

  logic                         run, ev_clr, cy_clr, en_cyc;
  logic [NUM_EV-1:0]            en_ev;
  logic [NUM_EV-1:0][1:0]       sel;
  logic [NUM_EV-1:0][CNT_W-1:0] ev_lo;
  logic [EXT_W-1:0]             ev_hi;
  logic [CNT_W-1:0]             cyc_cnt;
  logic [BUS_W-1:0]             rd_mux;
  reg_addr_e                    a_dec;

  bustraf_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .run    (run),
    .ev_clr (ev_clr),
    .cy_clr (cy_clr),
    .en_ev  (en_ev),
    .en_cyc (en_cyc),
    .sel    (sel)
  );

  bustraf_cnt #(.W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst    (rst),
    .clr    (cy_clr),
    .cnt_en (run && en_cyc),
    .inc    (2'd1),
    .count  (cyc_cnt)
  );

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    logic [1:0] inc;
    assign inc = {1'b0, rd_beat & sel[i][SEL_RD]} + {1'b0, wr_beat & sel[i][SEL_WR]};
    if (i == NUM_EV - 1) begin : g_wide
      logic [WIDE_W-1:0] c;
      bustraf_cnt #(.W(WIDE_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (ev_clr),
        .cnt_en (run && en_ev[i]),
        .inc    (inc),
        .count  (c)
      );
      assign ev_lo[i] = c[CNT_W-1:0];
      assign ev_hi    = c[WIDE_W-1:CNT_W];
    end else begin : g_std
      bustraf_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (ev_clr),
        .cnt_en (run && en_ev[i]),
        .inc    (inc),
        .count  (ev_lo[i])
      );
    end
  end

  assign a_dec = reg_addr_e'(addr);

  always_comb begin
    case (a_dec)
      A_CTRL:                      rd_mux = BUS_W'(run);
      A_EN_SET, A_EN_CLR:          rd_mux = (BUS_W'(en_cyc) << CYC_EN_BIT) | BUS_W'(en_ev);
      A_CYCLE:                     rd_mux = BUS_W'(cyc_cnt);
      A_SEL0, A_SEL1, A_SEL2, A_SEL3: rd_mux = BUS_W'(sel[addr[1:0]]);
      A_CNT0, A_CNT1, A_CNT2:      rd_mux = BUS_W'(ev_lo[addr[1:0]]);
      A_CNT3_LO:                   rd_mux = BUS_W'(ev_lo[NUM_EV-1]);
      A_CNT3_HI:                   rd_mux = BUS_W'(ev_hi);
      default:                     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && (addr > A_CNT3_HI)) |=> (rdata == '0)); // R10
  AST_RUN_HOLD_CYC: assert property (@(posedge clk) disable iff (rst) (!run && !cy_clr) |=> $stable(cyc_cnt)); // R7
endmodule

// File: tb/bustraf_mon_test.sv
`timescale 1ns/1ps
module bustraf_mon_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rd_beat = 1'b0, wr_beat = 1'b0;
  logic [31:0] rdata, rdata_n;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  bustraf_mon uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_beat(rd_beat), .wr_beat(wr_beat));

  bustraf_mon #(.CNT_W(8), .EXT_W(8)) uut_narrow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_n), .rd_beat(rd_beat), .wr_beat(wr_beat));

  // {counter id[13:12], select[11:10], read strobe[9], write strobe[8], beats[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 2'b01, 1'b1, 1'b0, 8'd10},
    {2'd0, 2'b10, 1'b1, 1'b0, 8'd10},
    {2'd1, 2'b10, 1'b0, 1'b1, 8'd25},
    {2'd1, 2'b11, 1'b1, 1'b1, 8'd40},
    {2'd2, 2'b11, 1'b1, 1'b0, 8'd7},
    {2'd2, 2'b00, 1'b1, 1'b1, 8'd30},
    {2'd3, 2'b11, 1'b1, 1'b1, 8'd255},
    {2'd3, 2'b01, 1'b0, 1'b1, 8'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] dn);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata; dn = rdata_n;
    rd_en = 1'b0;
  endtask

  task automatic burst(input int n, input logic r, input logic w);
    rd_beat = r; wr_beat = w;
    repeat (n) @(negedge clk);
    rd_beat = 1'b0; wr_beat = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, dn;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d, dn);  check("R1 ctrl", d, 0);
    rd(4'd1, d, dn);  check("R1 enables", d, 0);
    rd(4'd3, d, dn);  check("R1 cycle", d, 0);
    rd(4'd4, d, dn);  check("R1 select0", d, 0);
    rd(4'd8, d, dn);  check("R1 count0", d, 0);
    rd(4'd11, d, dn); check("R1 count3 low", d, 0);
    rd(4'd12, d, dn); check("R1 count3 high", d, 0);

    // R2 / R3 enable set and clear
    wr(4'd1, 32'h5);  rd(4'd1, d, dn); check("R2 set ones", d, 32'h5);
    wr(4'd1, 32'h2);  rd(4'd1, d, dn); check("R2 zeros keep", d, 32'h7);
    wr(4'd2, 32'h4);  rd(4'd1, d, dn); check("R3 clear ones", d, 32'h3);
    wr(4'd2, 32'h0);  rd(4'd1, d, dn); check("R3 zeros keep", d, 32'h3);
    wr(4'd1, 32'h8000_0000); rd(4'd2, d, dn); check("R2 cycle bit at clear addr", d, 32'h8000_0003);

    // R4 control readback
    wr(4'd0, 32'h7); rd(4'd0, d, dn); check("R4 clear bits read 0", d, 32'h1);
    wr(4'd0, 32'h0);

    // Vector table: R5 R6 R8
    for (int v = 0; v < 8; v++) begin
      logic [13:0] e;
      int cid, ocid, n, exp_ev;
      e = VEC[v];
      cid = int'(e[13:12]);
      ocid = (cid + 1) % 4;
      n = int'(e[7:0]);
      exp_ev = n * (((e[9] && e[10]) ? 1 : 0) + ((e[8] && e[11]) ? 1 : 0));
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd1, 32'h8000_0000 | (32'h1 << cid));
      wr(4'(4 + cid), {30'd0, e[11:10]});
      wr(4'd0, 32'h7);
      burst(n, e[9], e[8]);
      wr(4'd0, 32'h0);
      rd((cid < 3) ? 4'(8 + cid) : 4'd11, d, dn); check("R6 event count", d, exp_ev);
      rd(4'd3, d, dn); check("R5 cycle count", d, n + 1);
      rd((ocid < 3) ? 4'(8 + ocid) : 4'd11, d, dn); check("R2 disabled counter stays 0", d, 0);
      if (cid == 3) begin
        rd(4'd12, d, dn); check("R8 count3 high", d, 0);
      end
    end

    // R7 freeze
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd1, 32'h8000_0001);
    wr(4'd4, 32'h3);
    wr(4'd0, 32'h7);
    burst(20, 1'b1, 1'b1);
    wr(4'd0, 32'h0);
    rd(4'd3, d, dn); check("R5 cycle after burst", d, 21);
    burst(10, 1'b1, 1'b1);
    rd(4'd8, d, dn); check("R7 events frozen", d, 40);
    rd(4'd3, d, dn); check("R7 cycle frozen", d, 21);

    // R4 each clear bit acts on its own counters
    wr(4'd0, 32'h5);
    burst(5, 1'b1, 1'b0);
    wr(4'd0, 32'h0);
    rd(4'd8, d, dn); check("R4 cycle clear keeps events", d, 45);
    rd(4'd3, d, dn); check("R4 cycle cleared", d, 6);
    wr(4'd0, 32'h3);
    wr(4'd0, 32'h0);
    rd(4'd8, d, dn); check("R4 events cleared", d, 0);
    rd(4'd3, d, dn); check("R4 event clear keeps cycle", d, 7);

    // R9 wrap and R8 carry into high word, on the narrow instance
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd1, 32'h8000_0009);
    wr(4'd4, 32'h3);
    wr(4'd7, 32'h3);
    wr(4'd0, 32'h7);
    burst(300, 1'b1, 1'b1);
    wr(4'd0, 32'h0);
    rd(4'd8, d, dn);  check("R6 both strobes add 2", d, 600); check("R9 narrow count0 wraps", dn, 88);
    rd(4'd11, d, dn); check("R8 count3 low", d, 600); check("R8 narrow count3 low", dn, 88);
    rd(4'd12, d, dn); check("R8 count3 high", d, 0);  check("R8 narrow count3 high carry", dn, 2);
    rd(4'd3, d, dn);  check("R5 cycle 301", d, 301);  check("R9 narrow cycle wraps", dn, 45);
    wr(4'd0, 32'h7);
    burst(32800, 1'b1, 1'b1);
    wr(4'd0, 32'h0);
    rd(4'd11, d, dn); check("R8 count3 low long", d, 65600); check("R9 narrow count3 wraps low", dn, 64);
    rd(4'd12, d, dn); check("R9 narrow count3 wraps high", dn, 0);
    rd(4'd3, d, dn);  check("R9 narrow cycle long", dn, 33);

    // R10 unmapped addresses
    rd(4'd13, d, dn); check("R10 unmapped 13", d, 0);
    rd(4'd15, d, dn); check("R10 unmapped 15", d, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule